// File: doc/BRIEF.md
# Type-Code Addressed I2C Slave Front End

This block is the two-wire serial slave interface of a small byte-addressed storage device. It oversamples SCL and SDA with a fast system clock, recognises bus START and STOP conditions, and collects the address byte. It takes part in a transfer only when the upper four address bits equal a fixed type code. The lower three address bits are don't-care. SDA is driven open-drain: the block can only pull the line low, through an output enable.

In a write transfer, the first byte after the address sets an internal byte pointer. Each later byte goes out on a byte-wide write port at the pointer, and the pointer then advances. In a read transfer, the block sends bytes from the pointer location for as long as the master acknowledges them. When a write transfer ends with STOP, the block raises a one-cycle commit pulse so that the storage behind it can begin its internal programming cycle. The storage must present the read data for `mem_addr` on `mem_rdata` within a few system clocks.

Top module: `i2c_typecode_slave`

## Requirements
- R1: While `rst` is high, `sda_oe`, `mem_we` and `commit_pulse` are 0 and `mem_addr` is 0.
- R2: A START (SDA falling while SCL is high) seen at any point, including in the middle of a byte, discards the partial byte and restarts address reception.
- R3: The address byte is received MSB first as {code[3:0], don't-care[2:0], rw}, with rw=1 for a read. When code equals TYPE_CODE (default 4'b1010), the block pulls SDA low during the ninth SCL clock, whatever the don't-care bits are.
- R4: After an address byte whose code differs, SDA stays released, no ACK is given and no write strobe occurs until the next START.
- R5: In a write, every byte is acknowledged. The first data byte loads the pointer. Each later byte is written once at the pointer, and the pointer then increments modulo 2^AW.
- R6: In a read, the byte at the pointer is shifted out MSB first. On a master ACK the pointer increments and the next byte follows.
- R7: On a master NACK the block releases SDA until the next START or STOP. The pointer is not advanced for the NACKed byte, so a following read starts at that byte.
- R8: `commit_pulse` is high for exactly one cycle after a STOP that arrives at a byte boundary of a write in which at least one data byte was stored. It stays low after a pointer-only write, after a read, and after a STOP in the middle of a byte.
- R9: The block never drives SDA high. `sda_oe` changes only while the synchronized SCL is low, except for the release on START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_addr | output | AW | Byte pointer to storage |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data, valid with `mem_we` |
| mem_rdata | input | 8 | Storage data at `mem_addr` |
| commit_pulse | output | 1 | One-cycle request to start the non-volatile write |

## Verification
Assertions check four rules on every cycle. The enable edge moves only while SCL is low or on a START/STOP release. The commit pulse is one cycle long and always follows a detected STOP. Write strobes come only out of byte reception in a write. SDA stays released in the idle and ignoring states. Only the bench's bus transactions can show the protocol results: acknowledge levels on the line, bytes read back against a model of storage, pointer wrap and the pointer position after a NACK, silence after a foreign type code, and the presence or absence of a commit after full writes, pointer-only writes and STOPs in the middle of a byte.

// File: rtl/i2c_tc_pkg.sv
`timescale 1ns/1ps
package i2c_tc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sampler.sv
`timescale 1ns/1ps
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sync, sda_sync;
  logic         scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[TOP-1:0], scl_i};
      sda_sync <= {sda_sync[TOP-1:0], sda_i};
      scl_d    <= scl_sync[TOP];
      sda_d    <= sda_sync[TOP];
    end
  end

  assign scl_lvl   = scl_sync[TOP];
  assign sda_lvl   = sda_sync[TOP];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_tc_engine.sv
`timescale 1ns/1ps
module i2c_tc_engine
  import i2c_tc_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE = 4'b1010,
  parameter int         AW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    mem_rdata,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          commit_pulse
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  slv_state_e    state;
  logic [3:0]    bitcnt;
  logic [7:0]    rx_sh, tx_sh;
  logic [AW-1:0] ptr;
  logic          rw, ptr_loaded, stored, data_byte, master_ack;
  logic          take_bit;

  assign take_bit = scl_rise && (bitcnt != BITS_PER_BYTE) &&
                    (state == ST_ADDR || state == ST_WR_BYTE);
  assign mem_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bitcnt       <= '0;
      rx_sh        <= '0;
      tx_sh        <= '0;
      ptr          <= '0;
      rw           <= 1'b0;
      ptr_loaded   <= 1'b0;
      stored       <= 1'b0;
      data_byte    <= 1'b0;
      master_ack   <= 1'b0;
      sda_oe       <= 1'b0;
      mem_we       <= 1'b0;
      mem_wdata    <= '0;
      commit_pulse <= 1'b0;
    end else begin
      mem_we       <= 1'b0;
      commit_pulse <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        stored <= 1'b0;
      end else if (stop_det) begin
        commit_pulse <= stored && (state == ST_WR_BYTE) && (bitcnt <= 4'd1);
        state        <= ST_IDLE;
        sda_oe       <= 1'b0;
        stored       <= 1'b0;
      end else begin
        if (take_bit) begin
          rx_sh  <= {rx_sh[6:0], sda_lvl};
          bitcnt <= bitcnt + 4'd1;
        end
        case (state)
          ST_ADDR: if (scl_fall && bitcnt == BITS_PER_BYTE) begin
            bitcnt <= '0;
            if (rx_sh[7:4] == TYPE_CODE) begin
              rw     <= rx_sh[0];
              sda_oe <= 1'b1;
              state  <= ST_ADDR_ACK;
              if (!rx_sh[0]) ptr_loaded <= 1'b0;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              tx_sh  <= mem_rdata;
              sda_oe <= ~mem_rdata[7];
              state  <= ST_RD_BYTE;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR_BYTE;
            end
          end
          ST_WR_BYTE: if (scl_fall && bitcnt == BITS_PER_BYTE) begin
            bitcnt <= '0;
            sda_oe <= 1'b1;
            state  <= ST_WR_ACK;
            if (ptr_loaded) begin
              mem_we    <= 1'b1;
              mem_wdata <= rx_sh;
              stored    <= 1'b1;
              data_byte <= 1'b1;
            end else begin
              ptr        <= AW'(rx_sh);
              ptr_loaded <= 1'b1;
              data_byte  <= 1'b0;
            end
          end
          ST_WR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WR_BYTE;
            if (data_byte) ptr <= ptr + 1'b1;
          end
          ST_RD_BYTE: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              bitcnt <= bitcnt + 4'd1;
              sda_oe <= ~tx_sh[6];
              tx_sh  <= {tx_sh[6:0], 1'b0};
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_lvl;
              if (!sda_lvl) ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (master_ack) begin
                tx_sh  <= mem_rdata;
                sda_oe <= ~mem_rdata[7];
                state  <= ST_RD_BYTE;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

  // R8
  commit_single_chk: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |=> !commit_pulse);

  // R8
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |-> $past(stop_det));

  // R4
  released_when_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

  // R5
  we_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(state) == ST_WR_BYTE));
endmodule

// File: rtl/i2c_typecode_slave.sv
`timescale 1ns/1ps
module i2c_typecode_slave #(
  parameter logic [3:0] TYPE_CODE   = 4'b1010,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          commit_pulse
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tc_engine #(.TYPE_CODE(TYPE_CODE), .AW(AW)) u_engine (
    .clk          (clk),
    .rst          (rst),
    .scl_lvl      (scl_lvl),
    .sda_lvl      (sda_lvl),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .mem_rdata    (mem_rdata),
    .sda_oe       (sda_oe),
    .mem_addr     (mem_addr),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .commit_pulse (commit_pulse)
  );
endmodule

// File: tb/i2c_typecode_slave_test.sv
`timescale 1ns/1ps
module i2c_typecode_slave_test;
  localparam int         AW = 8;
  localparam int         Q  = 8;
  localparam logic [3:0] TC = 4'b1010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          scl_m = 1'b1;
  logic          m_low = 1'b0;
  logic          sda_line;
  logic          sda_oe, mem_we, commit_pulse;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  assign sda_line = ~(m_low | sda_oe);

  i2c_typecode_slave #(.TYPE_CODE(TC), .AW(AW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .commit_pulse(commit_pulse)
  );

  int vectors = 0, fails = 0;
  int commit_cnt = 0, we_cnt = 0, oe_viol = 0;
  logic scl_prev_n = 1'b1, oe_prev_n = 1'b0;
  logic [7:0] bmem  [256];
  logic [7:0] model [256];

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] addr_byte(logic [3:0] code, logic [2:0] low, logic rd);
    return {code, low, rd};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) bmem[i] <= init_val(i);
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      mem_rdata <= bmem[mem_addr];
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (commit_pulse) commit_cnt++;
      if (mem_we) we_cnt++;
      if (scl_m && scl_prev_n && (sda_oe != oe_prev_n)) oe_viol++;
    end
    scl_prev_n = scl_m;
    oe_prev_n  = sda_oe;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_low = 1'b0; qw();
    scl_m = 1'b1; qw();
    m_low = 1'b1; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qw();
    scl_m = 1'b1; qw();
    m_low = 1'b0; qw();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_low = ~b; qw();
    scl_m = 1'b1; qw();
    s = sda_line;
    scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic do_write(input logic [2:0] low, input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] d;
    int c0 = commit_cnt;
    bus_start();
    send_byte(addr_byte(TC, low, 1'b0), ack);
    chk("R3", "write address ack", ack, 1);
    send_byte(p, ack);
    chk("R5", "pointer byte ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      chk("R5", "data byte ack", ack, 1);
      model[8'(p + k)] = d;
    end
    bus_stop();
    chk("R8", "commit count after write", commit_cnt, c0 + ((n > 0) ? 1 : 0));
    for (int k = 0; k < n; k++)
      chk("R5", "stored byte", bmem[8'(p + k)], model[8'(p + k)]);
  endtask

  task automatic do_read(input logic [2:0] low, input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] b;
    int c0 = commit_cnt;
    bus_start();
    send_byte(addr_byte(TC, low, 1'b0), ack);
    chk("R3", "address ack before read", ack, 1);
    send_byte(p, ack);
    bus_start();
    send_byte(addr_byte(TC, ~low, 1'b1), ack);
    chk("R3", "read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk("R6", "read byte", b, model[8'(p + k)]);
    end
    chk("R7", "released after NACK", sda_oe, 0);
    bus_stop();
    chk("R8", "no commit after read", commit_cnt, c0);
  endtask

  task automatic foreign_txn(input logic [3:0] code, input logic [7:0] p);
    logic ack;
    int w0 = we_cnt, c0 = commit_cnt;
    bus_start();
    send_byte(addr_byte(code, 3'($urandom), 1'b0), ack);
    chk("R4", "no ack for foreign code", ack, 0);
    send_byte(p, ack);
    chk("R4", "no ack on ignored byte", ack, 0);
    send_byte(8'($urandom), ack);
    chk("R4", "no ack on ignored data", ack, 0);
    bus_stop();
    chk("R4", "no writes while ignoring", we_cnt, w0);
    chk("R4", "no commit while ignoring", commit_cnt, c0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
    $finish;
  end

  initial begin
    logic ack, s;
    logic [7:0] b, d;
    int c0, code;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) model[i] = init_val(i);
    repeat (6) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "sda_oe in reset", sda_oe, 0);
    chk("R1", "mem_we in reset", mem_we, 0);
    chk("R1", "commit in reset", commit_pulse, 0);
    chk("R1", "mem_addr in reset", mem_addr, 0);
    rst = 1'b0;
    qw();

    do_write(3'b011, 8'h10, 3);
    do_read(3'b101, 8'h10, 3);

    // R7: current read continues at the NACKed byte
    bus_start();
    send_byte(addr_byte(TC, 3'b000, 1'b1), ack);
    chk("R3", "current read ack", ack, 1);
    recv_byte(1'b0, b);
    chk("R7", "read after NACK starts at NACKed byte", b, model[8'h12]);
    bus_stop();

    // R5 pointer wrap
    do_write(3'b000, 8'hFF, 2);
    do_read(3'b111, 8'hFF, 2);

    // R8 pointer-only write gives no commit
    do_write(3'b010, 8'h30, 0);

    // R4 foreign type code
    foreign_txn(4'b1011, 8'h50);
    do_read(3'b001, 8'h50, 2);

    // R8 STOP in the middle of a byte
    c0 = commit_cnt;
    bus_start();
    send_byte(addr_byte(TC, 3'b100, 1'b0), ack);
    send_byte(8'h60, ack);
    d = 8'hA5;
    send_byte(d, ack);
    model[8'h60] = d;
    for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
    bus_stop();
    chk("R8", "no commit on mid-byte STOP", commit_cnt, c0);
    chk("R5", "byte before mid-byte STOP stored", bmem[8'h60], d);

    // R2 START in the middle of a byte
    c0 = commit_cnt;
    bus_start();
    send_byte(addr_byte(TC, 3'b110, 1'b0), ack);
    send_byte(8'h70, ack);
    d = 8'h3C;
    send_byte(d, ack);
    model[8'h70] = d;
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_start();
    send_byte(addr_byte(TC, 3'b110, 1'b1), ack);
    chk("R2", "address ack after aborting START", ack, 1);
    recv_byte(1'b0, b);
    chk("R2", "read after aborted byte", b, model[8'h71]);
    bus_stop();
    chk("R8", "no commit after aborted write", commit_cnt, c0);

    // random mix
    for (int it = 0; it < 16; it++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom);
      n = 1 + int'($urandom % 4);
      if ($urandom % 4 == 0) begin
        code = int'($urandom % 15);
        if (code >= 10) code++;
        foreign_txn(4'(code), p);
      end else begin
        do_write(3'($urandom), p, n);
        do_read(3'($urandom), p, n);
      end
    end

    chk("R9", "enable changes while SCL high", oe_viol, 0);
    report();
    $finish;
  end
endmodule